// File: doc/BRIEF.md
# Flash Page Programming Controller

This block is the programming engine that sits behind a serial in-system programming port. It keeps several nonvolatile spaces: code, data, a user signature, a factory signature that cannot be written, a fuse row and a set of lock bytes. All of them are held in internal registers and share one page geometry of 128 bytes. A command names an operation (read, write, write with auto-erase, or chip erase), a space, a start address and a length of up to half a page. Write data then arrives one byte per accepted beat on a valid/ready stream. Read data leaves on a valid-only stream, one byte per cycle.

Every cell erases to FFh. A plain write ANDs the new byte into the stored one, so it can only clear bits. The write-with-auto-erase command first sets the whole addressed page to FFh and then stores the supplied half page. The fuse row uses these same rules, so a fuse can be enabled at any time but returns to FFh only when its row is erased and written again. Lock bytes ignore the auto-erase step and are released only by chip erase. Chip erase clears code, data and lock bytes. It leaves both signature spaces and the fuse row as they were. While an operation runs, and for a fixed programming time after it, `busy` stays high and any new command is dropped.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, `busy`, `outValid` and `inReady` are low. Every cell reads FFh except the factory signature, where byte k reads (k*7+30) mod 256.
- R2: A read command whose `cmdLen` is 1 to 64 produces exactly that many `outValid` cycles, with no gap between them. The first comes in the cycle after the command is accepted. A `cmdLen` of 0 or above 64 counts as 64.
- R3: A plain write (`cmdOp`=1) stores the AND of the old byte and the new byte.
- R4: Byte k of a command addresses {addr[15:6], (addr[5:0]+k) mod 64}, so the byte address wraps inside the half page.
- R5: A write with auto-erase (`cmdOp`=2) to code, data, user signature or fuse space sets all bytes of the 128-byte page at addr[15:7] to FFh before the supplied bytes are written.
- R6: The factory signature (space 3) is never changed by a write, an auto-erase or a chip erase.
- R7: In the fuse row (space 4), a plain write can only clear bits. A write with auto-erase at any fuse address restores the whole row to FFh before it writes.
- R8: Lock bytes (space 5) can only be cleared by writing. Auto-erase does not touch them. Chip erase returns them to FFh.
- R9: Chip erase (`cmdOp`=3) sets code (space 0), data (space 1) and lock bytes to FFh. It leaves the user signature (space 2), the factory signature and the fuse row unchanged.
- R10: `busy` is high from the cycle after acceptance until the operation ends. It stays high for exactly BUSY_CYCLES cycles after the last write byte, and for BUSY_CYCLES+1 cycles after a chip erase is accepted. A command presented while `busy` is high is ignored.
- R11: An address at or beyond the size of its space, or a space code of 6 or 7, reads FFh, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command strobe, accepted when busy is low |
| cmdOp | input | 2 | 0 read, 1 write, 2 write with auto-erase, 3 chip erase |
| cmdSpace | input | 3 | 0 code, 1 data, 2 user sig, 3 factory sig, 4 fuse, 5 lock |
| cmdAddr | input | 16 | Start byte address within the space |
| cmdLen | input | 7 | Byte count, 1 to 64 |
| inValid | input | 1 | Write byte valid |
| inData | input | 8 | Write byte |
| inReady | output | 1 | Engine takes a write byte this cycle |
| outValid | output | 1 | Read byte valid |
| outData | output | 8 | Read byte |
| busy | output | 1 | Operation in progress, commands ignored |

## Verification
A wrong array state stays hidden until a later read of the damaged half page. The cost of a fault therefore depends on how many reads the bench issues after each write, erase and chip erase. The bench reads back every affected half page, plus the neighbouring half and the spaces that must survive, as soon as `busy` falls. A control fault that loses the count or the state shows up at once, as a `busy` window of the wrong length or an `outValid` byte the scoreboard did not expect.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef enum logic [1:0] {
    OP_READ    = 2'd0,
    OP_WRITE   = 2'd1,
    OP_WRERASE = 2'd2,
    OP_CHIP    = 2'd3
  } opE;

  typedef struct packed {
    logic wrEn;
    logic pageErase;
    logic chipErase;
  } strobeS;
endpackage

// File: rtl/flash_prog_ctrl_fsm.sv
module flash_prog_ctrl_fsm
  import flash_prog_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 6,
  parameter int unsigned HALF_BYTES  = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic [2:0]  cmdSpace,
  input  logic [15:0] cmdAddr,
  input  logic [6:0]  cmdLen,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  output logic        busy,
  output strobeS      st,
  output logic [2:0]  curSpace,
  output logic [15:0] curAddr
);
  localparam int unsigned OFF_W = $clog2(HALF_BYTES);
  localparam int unsigned TMR_W = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_ERS, ST_WR, ST_CER, ST_PROG} stateE;

  stateE            state;
  logic [6:0]       lenQ;
  logic [OFF_W-1:0] cnt;
  logic [15:0]      baseAddr;
  logic [TMR_W-1:0] timer;
  logic             lastBeat;
  logic [OFF_W-1:0] offSum;

  assign offSum   = baseAddr[OFF_W-1:0] + cnt;
  assign curAddr  = {baseAddr[15:OFF_W], offSum};
  assign lastBeat = ({1'b0, cnt} == (lenQ - 7'd1));
  assign busy     = (state != ST_IDLE);
  assign outValid = (state == ST_RD);
  assign inReady  = (state == ST_WR);

  always_comb begin
    st           = '0;
    st.wrEn      = (state == ST_WR) && inValid;
    st.pageErase = (state == ST_ERS);
    st.chipErase = (state == ST_CER);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lenQ     <= 7'd0;
      cnt      <= '0;
      baseAddr <= '0;
      curSpace <= '0;
      timer    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cmdValid) begin
          cnt      <= '0;
          baseAddr <= cmdAddr;
          curSpace <= cmdSpace;
          lenQ     <= (cmdLen == 7'd0 || cmdLen > 7'(HALF_BYTES)) ? 7'(HALF_BYTES) : cmdLen;
          case (opE'(cmdOp))
            OP_READ:    state <= ST_RD;
            OP_WRITE:   state <= ST_WR;
            OP_WRERASE: state <= ST_ERS;
            default:    state <= ST_CER;
          endcase
        end
        ST_RD: begin
          cnt <= cnt + 1'b1;
          if (lastBeat) state <= ST_IDLE;
        end
        ST_ERS: state <= ST_WR;
        ST_WR: if (inValid) begin
          cnt <= cnt + 1'b1;
          if (lastBeat) begin
            state <= ST_PROG;
            timer <= TMR_W'(BUSY_CYCLES);
          end
        end
        ST_CER: begin
          state <= ST_PROG;
          timer <= TMR_W'(BUSY_CYCLES);
        end
        default: begin
          timer <= timer - 1'b1;
          if (timer == TMR_W'(1)) state <= ST_IDLE;
        end
      endcase
    end
  end

  // R2
  rd_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ({1'b0, cnt} < lenQ));
  // R10
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(state == ST_PROG || state == ST_RD));
  // R10
  prog_timer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROG) |-> (timer != '0));
  // R5
  erase_then_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.pageErase |=> inReady);
endmodule

// File: rtl/flash_prog_array.sv
module flash_prog_array
  import flash_prog_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 128,
  parameter int unsigned CODE_PAGES = 4,
  parameter int unsigned DATA_PAGES = 2,
  parameter int unsigned USIG_PAGES = 2,
  parameter int unsigned FUSE_BYTES = 8,
  parameter int unsigned LOCK_BYTES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobeS      st,
  input  logic [2:0]  space,
  input  logic [15:0] addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData
);
  localparam int unsigned CODE_SZ   = CODE_PAGES * PAGE_BYTES;
  localparam int unsigned DATA_SZ   = DATA_PAGES * PAGE_BYTES;
  localparam int unsigned USIG_SZ   = USIG_PAGES * PAGE_BYTES;
  localparam int unsigned FSIG_SZ   = PAGE_BYTES;
  localparam int unsigned DATA_BASE = CODE_SZ;
  localparam int unsigned USIG_BASE = DATA_BASE + DATA_SZ;
  localparam int unsigned FSIG_BASE = USIG_BASE + USIG_SZ;
  localparam int unsigned FUSE_BASE = FSIG_BASE + FSIG_SZ;
  localparam int unsigned LOCK_BASE = FUSE_BASE + FUSE_BYTES;
  localparam int unsigned TOTAL     = LOCK_BASE + LOCK_BYTES;
  localparam int unsigned IDX_W     = $clog2(TOTAL);

  logic [7:0] mem [TOTAL];

  function automatic int unsigned sizeOf(int unsigned s);
    case (s)
      0: return CODE_SZ;   1: return DATA_SZ;    2: return USIG_SZ;
      3: return FSIG_SZ;   4: return FUSE_BYTES; 5: return LOCK_BYTES;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned baseOf(int unsigned s);
    case (s)
      1: return DATA_BASE; 2: return USIG_BASE; 3: return FSIG_BASE;
      4: return FUSE_BASE; 5: return LOCK_BASE; default: return 0;
    endcase
  endfunction

  function automatic int unsigned regionOf(int unsigned i);
    if (i < DATA_BASE) return 0;
    if (i < USIG_BASE) return 1;
    if (i < FSIG_BASE) return 2;
    if (i < FUSE_BASE) return 3;
    if (i < LOCK_BASE) return 4;
    return 5;
  endfunction

  logic             hit;
  logic             wrOk;
  logic             pageErasable;
  logic [IDX_W-1:0] idx;

  assign hit          = (int'(addr) < int'(sizeOf(int'(space))));
  assign idx          = IDX_W'(baseOf(int'(space)) + int'(addr));
  assign wrOk         = hit && (space != 3'd3);
  assign pageErasable = (space <= 3'd2) || (space == 3'd4);
  assign rdData       = hit ? mem[idx] : 8'hFF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TOTAL; i++)
        mem[i] <= (regionOf(i) == 3) ? 8'((i - FSIG_BASE) * 7 + 30) : 8'hFF;
    end else begin
      for (int i = 0; i < TOTAL; i++) begin
        if (st.chipErase && (regionOf(i) <= 1 || regionOf(i) == 5))
          mem[i] <= 8'hFF;
        else if (st.pageErase && pageErasable && regionOf(i) == int'(space) &&
                 ((i - baseOf(regionOf(i))) / PAGE_BYTES) == (int'(addr) / PAGE_BYTES))
          mem[i] <= 8'hFF;
      end
      if (st.wrEn && wrOk) mem[idx] <= mem[idx] & wrData;
    end
  end

  // R3
  wr_and_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrEn && wrOk) |=> (mem[$past(idx)] == $past(mem[idx] & wrData)));
  // R6
  fsig_const_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(mem[FSIG_BASE]) && $stable(mem[FUSE_BASE - 1]));
  // R7
  fuse_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(st.pageErase) |-> ((mem[FUSE_BASE] & ~$past(mem[FUSE_BASE])) == 8'h00));
  // R9
  chip_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.chipErase |=> (mem[0] == 8'hFF && mem[DATA_BASE] == 8'hFF && mem[LOCK_BASE] == 8'hFF));
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int unsigned PAGE_BYTES  = 128,
  parameter int unsigned CODE_PAGES  = 4,
  parameter int unsigned DATA_PAGES  = 2,
  parameter int unsigned USIG_PAGES  = 2,
  parameter int unsigned FUSE_BYTES  = 8,
  parameter int unsigned LOCK_BYTES  = 4,
  parameter int unsigned BUSY_CYCLES = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic [2:0]  cmdSpace,
  input  logic [15:0] cmdAddr,
  input  logic [6:0]  cmdLen,
  input  logic        inValid,
  input  logic [7:0]  inData,
  output logic        inReady,
  output logic        outValid,
  output logic [7:0]  outData,
  output logic        busy
);
  localparam int unsigned HALF_BYTES = PAGE_BYTES / 2;

  strobeS      st;
  logic [2:0]  curSpace;
  logic [15:0] curAddr;

  flash_prog_ctrl_fsm #(.BUSY_CYCLES(BUSY_CYCLES), .HALF_BYTES(HALF_BYTES)) u_fsm (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdSpace(cmdSpace),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .busy(busy), .st(st), .curSpace(curSpace), .curAddr(curAddr)
  );

  flash_prog_array #(
    .PAGE_BYTES(PAGE_BYTES), .CODE_PAGES(CODE_PAGES), .DATA_PAGES(DATA_PAGES),
    .USIG_PAGES(USIG_PAGES), .FUSE_BYTES(FUSE_BYTES), .LOCK_BYTES(LOCK_BYTES)
  ) u_array (
    .clk(clk), .rstN(rstN), .st(st), .space(curSpace), .addr(curAddr),
    .wrData(inData), .rdData(outData)
  );
endmodule

// File: tb/flash_prog_ctrl_bench.sv
module flash_prog_ctrl_bench;
  localparam int BUSY = 6;
  localparam int TOT  = 1164;

  logic        clk = 0;
  logic        rstN = 0;
  logic        cmdValid = 0;
  logic [1:0]  cmdOp = 0;
  logic [2:0]  cmdSpace = 0;
  logic [15:0] cmdAddr = 0;
  logic [6:0]  cmdLen = 0;
  logic        inValid = 0;
  logic [7:0]  inData = 0;
  logic        inReady, outValid, busy;
  logic [7:0]  outData;

  flash_prog_ctrl #(.BUSY_CYCLES(BUSY)) u_flash_prog_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdSpace(cmdSpace),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outData(outData), .busy(busy)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] mdl [TOT];
  logic [7:0] wbuf [64];
  logic [7:0] expQ [$];
  string      tagQ [$];

  function automatic int mSize(int s);
    case (s) 0: return 512; 1: return 256; 2: return 256; 3: return 128;
             4: return 8;   5: return 4;   default: return 0; endcase
  endfunction
  function automatic int mBase(int s);
    case (s) 1: return 512; 2: return 768; 3: return 1024; 4: return 1152;
             5: return 1160; default: return 0; endcase
  endfunction
  function automatic logic [15:0] byteAddr(logic [15:0] a, int k);
    return {a[15:6], 6'(a[5:0] + k)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (outValid) begin
    if (expQ.size() == 0) begin
      checks++; fails++;
      $display("FAIL R10: unexpected read byte %0h expected none", outData);
    end else begin
      automatic logic [7:0] e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      check(t, 32'(outData), 32'(e));
    end
  end

  task automatic doRead(int sp, logic [15:0] a, int len, string tag);
    automatic int n = (len == 0 || len > 64) ? 64 : len;
    for (int k = 0; k < n; k++) begin
      automatic logic [15:0] b = byteAddr(a, k);
      automatic logic [7:0] e = 8'hFF;
      if (int'(b) < mSize(sp)) e = mdl[mBase(sp) + int'(b)];
      expQ.push_back(e); tagQ.push_back(tag);
    end
    @(negedge clk);
    cmdValid = 1; cmdOp = 2'd0; cmdSpace = 3'(sp); cmdAddr = a; cmdLen = 7'(len);
    @(negedge clk);
    cmdValid = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    check({tag, " drain"}, expQ.size(), 0);
  endtask

  task automatic doWrite(int op, int sp, logic [15:0] a, int len, bit probe);
    if (op == 2 && (sp <= 2 || sp == 4))
      for (int i = 0; i < mSize(sp); i++)
        if (i / 128 == int'(a) / 128) mdl[mBase(sp) + i] = 8'hFF;
    for (int k = 0; k < len; k++) begin
      automatic logic [15:0] b = byteAddr(a, k);
      if (int'(b) < mSize(sp) && sp != 3) mdl[mBase(sp) + int'(b)] &= wbuf[k];
    end
    @(negedge clk);
    cmdValid = 1; cmdOp = 2'(op); cmdSpace = 3'(sp); cmdAddr = a; cmdLen = 7'(len);
    @(negedge clk);
    cmdValid = 0;
    for (int k = 0; k < len; k++) begin
      while (!inReady) @(negedge clk);
      inValid = 1; inData = wbuf[k];
      @(negedge clk);
    end
    inValid = 0;
    begin
      automatic int n = 0;
      while (busy) begin
        n++;
        if (probe && n == 1) begin cmdValid = 1; cmdOp = 2'd3; end
        if (probe && n == 3) cmdValid = 0;
        @(negedge clk);
      end
      cmdValid = 0;
      check("R10 program window", n, BUSY);
    end
  endtask

  task automatic doChip();
    for (int i = 0; i < TOT; i++)
      if (i < 768 || i >= 1160) mdl[i] = 8'hFF;
    @(negedge clk);
    cmdValid = 1; cmdOp = 2'd3;
    @(negedge clk);
    cmdValid = 0;
    begin
      automatic int n = 0;
      while (busy) begin n++; @(negedge clk); end
      check("R10 chip window", n, BUSY + 1);
    end
  endtask

  initial begin
    for (int i = 0; i < TOT; i++) mdl[i] = (i >= 1024 && i < 1152) ? 8'((i - 1024) * 7 + 30) : 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 outValid", outValid, 0);
    check("R1 inReady", inReady, 0);
    doRead(0, 16'h0000, 64, "R1");
    doRead(3, 16'h0000, 64, "R1");
    doRead(3, 16'h0040, 0, "R2");
    doRead(4, 16'h0000, 8, "R1");
    // R3 plain writes AND into stored bytes
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'hF0; wbuf[3] = 8'h0F;
    doWrite(1, 0, 16'h0010, 4, 0);
    doRead(0, 16'h0010, 4, "R3");
    wbuf[0] = 8'h0F; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF; wbuf[3] = 8'hF0;
    doWrite(1, 0, 16'h0010, 4, 0);
    doRead(0, 16'h0010, 5, "R3");
    // R4 wrap inside half page
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    doWrite(1, 0, 16'h00BE, 4, 0);
    doRead(0, 16'h0080, 64, "R4");
    doRead(0, 16'h00C0, 2, "R4");
    // R5 auto-erase clears the whole page
    wbuf[0] = 8'h5A; wbuf[1] = 8'h6B;
    doWrite(2, 0, 16'h0040, 2, 0);
    doRead(0, 16'h0000, 64, "R5");
    doRead(0, 16'h0040, 64, "R5");
    doRead(0, 16'h0080, 4, "R5");
    // R6 factory signature not writable
    wbuf[0] = 8'h00; wbuf[1] = 8'h00;
    doWrite(1, 3, 16'h0000, 2, 0);
    doWrite(2, 3, 16'h0040, 2, 0);
    doRead(3, 16'h0000, 64, "R6");
    doRead(3, 16'h0040, 64, "R6");
    // R7 fuse rules
    wbuf[0] = 8'h00; wbuf[1] = 8'hFF; wbuf[2] = 8'h5A;
    doWrite(1, 4, 16'h0000, 3, 0);
    wbuf[0] = 8'hFF;
    doWrite(1, 4, 16'h0000, 1, 0);
    doRead(4, 16'h0000, 8, "R7");
    wbuf[0] = 8'hF0;
    doWrite(2, 4, 16'h0002, 1, 0);
    doRead(4, 16'h0000, 8, "R7");
    // R8 lock bytes
    wbuf[0] = 8'h00;
    doWrite(1, 5, 16'h0001, 1, 0);
    wbuf[0] = 8'hFF;
    doWrite(2, 5, 16'h0000, 1, 0);
    doRead(5, 16'h0000, 4, "R8");
    // user signature and data content
    wbuf[0] = 8'h12; wbuf[1] = 8'h34;
    doWrite(1, 2, 16'h0080, 2, 0);
    // R10 commands while busy are dropped
    wbuf[0] = 8'h77; wbuf[1] = 8'h88;
    doWrite(1, 1, 16'h0005, 2, 1);
    doRead(1, 16'h0000, 8, "R10");
    doRead(0, 16'h0040, 4, "R10");
    // R9 chip erase
    wbuf[0] = 8'h00;
    doWrite(1, 4, 16'h0005, 1, 0);
    doChip();
    doRead(0, 16'h0040, 64, "R9");
    doRead(1, 16'h0000, 8, "R9");
    doRead(5, 16'h0000, 4, "R9");
    doRead(2, 16'h0080, 4, "R9");
    doRead(4, 16'h0000, 8, "R9");
    doRead(3, 16'h0000, 8, "R9");
    // R11 out-of-range addresses and unused spaces
    wbuf[0] = 8'h00; wbuf[1] = 8'h00;
    doWrite(1, 0, 16'h0200, 2, 0);
    doRead(0, 16'h0200, 3, "R11");
    doRead(4, 16'h0008, 3, "R11");
    doRead(6, 16'h0000, 3, "R11");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule